// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache Controller

This block places a small direct-mapped cache between a processor port and a main-memory port. Each cache line holds a single 32-bit word, a valid flag and a tag. A read that finds its word in the cache returns it in the same cycle. A read that does not find its word holds the processor stalled while the controller fetches the word from memory. The controller then installs the word in the line, and the held access completes as a hit.

Every write updates the cache line and is also queued in a four-entry posted write buffer. The buffer drains into memory in issue order, so the processor waits on a write only when the buffer is full. A read miss goes to memory only after the buffer has emptied, which means memory never answers with a value older than one the processor has already written. The processor keeps its request fields steady while the stall output is high. The memory side keeps its request fields steady until memory pulses its done signal.

Top module: `wt_cache_ctrl`

## Requirements
- R1: The line index is word-address bits [INDEX_W+1:2] and the tag is the address bits above them. Byte-offset bits [1:0] play no part in lookup, so any byte address inside a cached word hits that word.
- R2: A read hit drives the stored word onto `cpu_rdata` in the same cycle, keeps `cpu_stall` low and issues no memory read.
- R3: A read miss raises `cpu_stall` and issues a memory read (`mem_we`=0) whose `mem_addr` equals the processor's byte address.
- R4: When `mem_done` ends a read, the returned word is written into the line with the new tag and valid set. In the following cycle the held read completes as a hit with that word.
- R5: Any write, hit or miss, overwrites the tag and data of its line with no refill. A later read of that address hits with the new word, and a read of the address it displaced misses.
- R6: Every accepted write reaches memory as a memory write with the full byte address and data, in the order the processor issued them.
- R7: The processor is stalled on a write only while the write buffer holds 4 entries. With room in the buffer, a write is accepted in its first cycle.
- R8: A memory read is issued only when the write buffer is empty.
- R9: Active-low `rst_n` clears every valid flag, so the first read to any address after reset misses. In reset, `cpu_stall` and `mem_req` are low while no request is made.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_done` is high.
- R11: A hit needs both the valid flag and a tag match. An address that maps to a valid line holding a different tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid when a read completes |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory request complete, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a read miss arriving while the buffer still holds writes, one of which targets the missing word. The stimulus issues a back-to-back burst of writes against a slow memory model. The burst fills the buffer and evicts one written line with a later write to the same index. The bench then reads the evicted address at once. The memory model flags any read that starts while buffered writes are still owed to memory, and the returned word must be the newly written value.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

   // Memory-port sequencer states
   typedef enum logic [1:0] {
      MP_IDLE  = 2'd0,
      MP_WRITE = 2'd1,
      MP_READ  = 2'd2
   } mport_state_e;

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
   parameter int WA_W    = 30,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WA_W-1:0]   lk_waddr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [WA_W-1:0]   wr_waddr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int LINES = 1 << INDEX_W;
   localparam int TAG_W = WA_W - INDEX_W;

   logic [LINES-1:0]   valid_q;
   logic [TAG_W-1:0]   tag_q  [LINES];
   logic [DATA_W-1:0]  data_q [LINES];

   logic [INDEX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0]   lk_tag, wr_tag;

   assign lk_idx = lk_waddr[INDEX_W-1:0];
   assign lk_tag = lk_waddr[WA_W-1:INDEX_W];
   assign wr_idx = wr_waddr[INDEX_W-1:0];
   assign wr_tag = wr_waddr[WA_W-1:INDEX_W];

   for (genvar g = 0; g < LINES; g++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            valid_q[g] <= 1'b0;
         else if (wr_en && (wr_idx == INDEX_W'(g)))
            valid_q[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = data_q[lk_idx];

endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full
);
   if (DEPTH == 1) begin : g_single
      logic              held_q;
      logic [ADDR_W-1:0] addr_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_q <= 1'b0;
         else if (push)
            held_q <= 1'b1;
         else if (pop)
            held_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (push) begin
            addr_q <= push_addr;
            data_q <= push_data;
         end
      end

      assign head_addr = addr_q;
      assign head_data = data_q;
      assign empty     = !held_q;
      assign full      = held_q;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(DEPTH + 1);

      logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
      logic [CNT_W-1:0]  cnt_q;
      logic [ADDR_W-1:0] addr_q [DEPTH];
      logic [DATA_W-1:0] data_q [DEPTH];
      logic              do_push, do_pop;

      assign do_push = push && !full;
      assign do_pop  = pop && !empty;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
         end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
         end
      end

      assign head_addr = addr_q[rd_ptr_q];
      assign head_data = data_q[rd_ptr_q];
      assign empty     = (cnt_q == '0);
      assign full      = (cnt_q == CNT_W'(DEPTH));
   end

endmodule

// File: rtl/wt_mem_port.sv
module wt_mem_port
   import wt_cache_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_empty,
   input  logic [ADDR_W-1:0] wb_head_addr,
   input  logic [DATA_W-1:0] wb_head_data,
   output logic              wb_pop,
   input  logic              rd_miss,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              fill_en,
   output logic [ADDR_W-1:0] fill_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_done
);
   mport_state_e      st_q, st_d;
   logic [ADDR_W-1:0] rd_addr_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         MP_IDLE: begin
            // buffered writes always go first so a miss sees fresh memory
            if (!wb_empty)    st_d = MP_WRITE;
            else if (rd_miss) st_d = MP_READ;
         end
         MP_WRITE: if (mem_done) st_d = MP_IDLE;
         MP_READ:  if (mem_done) st_d = MP_IDLE;
         default:  st_d = MP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= MP_IDLE;
         rd_addr_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == MP_IDLE && wb_empty && rd_miss)
            rd_addr_q <= rd_addr;
      end
   end

   assign mem_req   = (st_q != MP_IDLE);
   assign mem_we    = (st_q == MP_WRITE);
   assign mem_addr  = (st_q == MP_WRITE) ? wb_head_addr : rd_addr_q;
   assign mem_wdata = (st_q == MP_WRITE) ? wb_head_data : '0;
   assign wb_pop    = (st_q == MP_WRITE) && mem_done;
   assign fill_en   = (st_q == MP_READ) && mem_done;
   assign fill_addr = rd_addr_q;

endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int INDEX_W  = 6,
   parameter int WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done
);
   localparam int WA_W = ADDR_W - 2;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("wt_cache_ctrl: DATA_W must be 32 for one-word lines");
   end
   if (INDEX_W < 1 || ADDR_W < INDEX_W + 3) begin : g_bad_index_w
      $error("wt_cache_ctrl: INDEX_W does not fit inside ADDR_W");
   end
   if (WB_DEPTH < 1 || (WB_DEPTH & (WB_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wt_cache_ctrl: WB_DEPTH must be a power of two");
   end

   logic              lk_hit;
   logic [DATA_W-1:0] lk_data;
   logic              wb_empty, wb_full, wb_pop;
   logic [ADDR_W-1:0] wb_head_addr;
   logic [DATA_W-1:0] wb_head_data;
   logic              fill_en;
   logic [ADDR_W-1:0] fill_addr;
   logic              rd_miss, wr_accept;
   logic              st_wr_en;
   logic [WA_W-1:0]   st_wr_waddr;
   logic [DATA_W-1:0] st_wr_data;

   assign rd_miss   = cpu_req && !cpu_we && !lk_hit;
   assign wr_accept = cpu_req && cpu_we && !wb_full && !fill_en;
   assign cpu_stall = cpu_req && (cpu_we ? (wb_full || fill_en) : !lk_hit);
   assign cpu_rdata = lk_data;

   // refill and processor write never coincide; refill takes the port
   assign st_wr_en    = fill_en || wr_accept;
   assign st_wr_waddr = fill_en ? fill_addr[ADDR_W-1:2] : cpu_addr[ADDR_W-1:2];
   assign st_wr_data  = fill_en ? mem_rdata : cpu_wdata;

   wt_line_store #(
      .WA_W    (WA_W),
      .DATA_W  (DATA_W),
      .INDEX_W (INDEX_W)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_waddr (cpu_addr[ADDR_W-1:2]),
      .lk_hit   (lk_hit),
      .lk_data  (lk_data),
      .wr_en    (st_wr_en),
      .wr_waddr (st_wr_waddr),
      .wr_data  (st_wr_data)
   );

   wt_write_buffer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (WB_DEPTH)
   ) wbuf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_accept),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .pop       (wb_pop),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data),
      .empty     (wb_empty),
      .full      (wb_full)
   );

   wt_mem_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) mport_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wb_empty     (wb_empty),
      .wb_head_addr (wb_head_addr),
      .wb_head_data (wb_head_data),
      .wb_pop       (wb_pop),
      .rd_miss      (rd_miss),
      .rd_addr      (cpu_addr),
      .fill_en      (fill_en),
      .fill_addr    (fill_addr),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_done     (mem_done)
   );

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_done,
   input logic              wb_empty,
   input logic              lk_hit
);
   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                  && $stable(mem_wdata)));

   // R8
   read_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> wb_empty);

   // R2
   hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && lk_hit) |-> !cpu_stall);

   // R4
   refill_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_req && !mem_we && mem_done && cpu_req && !cpu_we)
       ##1 (cpu_req && !cpu_we && $stable(cpu_addr))) |-> !cpu_stall);

   // R6
   write_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_stall) |=> !wb_empty);

endmodule

bind wt_cache_ctrl wt_cache_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_done  (mem_done),
   .wb_empty  (wb_empty),
   .lk_hit    (lk_hit)
);

// File: tb/wt_cache_ctrl_tb_top.sv
module wt_cache_ctrl_tb_top;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int LAT    = 4;
   localparam logic [31:0] STRIDE = 32'h100; // 64 lines x 4 bytes

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              cpu_stall;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic              mem_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int n_reads = 0;
   int n_writes_done = 0;
   int n_writes_issued = 0;

   logic [31:0] mem_arr [256];
   logic [31:0] shadow  [256];
   logic [63:0] exp_wr [$];
   int          cnt = 0;
   logic [ADDR_W-1:0] lat_addr = '0;

   always #10 clk = ~clk;

   wt_cache_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .cpu_stall (cpu_stall),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_done  (mem_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model and scoreboard monitor
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_done <= 1'b0;
         cnt      <= 0;
      end else if (mem_done) begin
         mem_done <= 1'b0;
         cnt      <= 0;
      end else if (mem_req) begin
         if (cnt == 0) begin
            lat_addr <= mem_addr;
            if (!mem_we)
               chk(exp_wr.size() == 0, "R8", "read issued with writes pending",
                   exp_wr.size(), 0);
         end else begin
            chk(mem_addr == lat_addr, "R10", "mem_addr moved", mem_addr, lat_addr);
         end
         if (cnt == LAT) begin
            mem_done <= 1'b1;
            if (mem_we) begin
               logic [63:0] e;
               mem_arr[mem_addr[9:2]] = mem_wdata;
               n_writes_done++;
               if (exp_wr.size() == 0) begin
                  chk(1'b0, "R6", "unexpected memory write", mem_addr, 0);
               end else begin
                  e = exp_wr.pop_front();
                  chk(mem_addr == e[63:32], "R6", "write address", mem_addr, e[63:32]);
                  chk(mem_wdata == e[31:0], "R6", "write data", mem_wdata, e[31:0]);
               end
            end else begin
               mem_rdata <= mem_arr[mem_addr[9:2]];
               n_reads++;
            end
         end
         cnt <= cnt + 1;
      end
   end

   task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output int stalls);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      stalls = 0;
      #1;
      while (cpu_stall) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      d = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0;
   endtask

   task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, output int stalls);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      stalls = 0;
      #1;
      while (cpu_stall) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      shadow[a[9:2]] = d;
      exp_wr.push_back({a, d});
      n_writes_issued++;
      @(posedge clk);
      #1 cpu_req = 1'b0;
   endtask

   task automatic drain();
      repeat (40) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int st, r0, s1, s2, s3, s4, s5, s6;
      for (int i = 0; i < 256; i++) begin
         mem_arr[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0101);
         shadow[i]  = mem_arr[i];
      end
      repeat (3) @(posedge clk);
      #1;
      chk(cpu_stall == 1'b0, "R9", "stall in reset", cpu_stall, 0);
      chk(mem_req == 1'b0, "R9", "mem_req in reset", mem_req, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R9 / R3 / R4: first read after reset misses and refills
      r0 = n_reads;
      cpu_read(32'h40, d, st);
      chk(st > 0, "R9", "first read stalled", st, 1);
      chk(n_reads == r0 + 1, "R3", "one memory read", n_reads, r0 + 1);
      chk(d == shadow[8'h10], "R4", "refilled word", d, shadow[8'h10]);

      // R2: same word hits with no stall and no memory read
      r0 = n_reads;
      cpu_read(32'h40, d, st);
      chk(st == 0, "R2", "hit stall cycles", st, 0);
      chk(d == shadow[8'h10], "R2", "hit data", d, shadow[8'h10]);
      chk(n_reads == r0, "R2", "no memory read on hit", n_reads, r0);

      // R1: byte offset ignored
      cpu_read(32'h43, d, st);
      chk(st == 0, "R1", "offset 3 hits", st, 0);
      chk(d == shadow[8'h10], "R1", "offset 3 data", d, shadow[8'h10]);

      // R11: same index, different tag misses; then original misses again
      cpu_read(32'h40 + STRIDE, d, st);
      chk(st > 0, "R11", "conflicting tag misses", st, 1);
      chk(d == shadow[8'h50], "R11", "conflict data", d, shadow[8'h50]);
      cpu_read(32'h40, d, st);
      chk(st > 0, "R11", "evicted line misses", st, 1);

      // R5: write miss installs line, read hits with new data
      cpu_write(32'h80, 32'h1234_5678, st);
      chk(st == 0, "R7", "single write no stall", st, 0);
      r0 = n_reads;
      cpu_read(32'h80, d, st);
      chk(st == 0, "R5", "read after write hits", st, 0);
      chk(d == 32'h1234_5678, "R5", "written data", d, 32'h1234_5678);
      chk(n_reads == r0, "R5", "no refill for write", n_reads, r0);
      drain();

      // R7 / R8 / R5: burst fills buffer, last write evicts the first
      cpu_write(32'h104, 32'hAAAA_0001, s1);
      cpu_write(32'h108, 32'hAAAA_0002, s2);
      cpu_write(32'h10C, 32'hAAAA_0003, s3);
      cpu_write(32'h110, 32'hAAAA_0004, s4);
      cpu_write(32'h114, 32'hAAAA_0005, s5);
      cpu_write(32'h104 + STRIDE, 32'hBBBB_0006, s6);
      chk((s1 | s2 | s3 | s4) == 0, "R7", "first four writes unstalled", s1 + s2 + s3 + s4, 0);
      chk(s5 > 0, "R7", "fifth write stalls on full buffer", s5, 1);
      cpu_read(32'h104, d, st);
      chk(st > 0, "R5", "displaced address misses", st, 1);
      chk(d == 32'hAAAA_0001, "R8", "miss returns buffered write", d, 32'hAAAA_0001);
      cpu_read(32'h104 + STRIDE, d, st);
      chk(st > 0, "R11", "refill displaced the written line", st, 1);
      chk(d == 32'hBBBB_0006, "R8", "second written word", d, 32'hBBBB_0006);
      drain();

      // R6: every write reached memory in order
      chk(exp_wr.size() == 0, "R6", "writes outstanding", exp_wr.size(), 0);
      chk(n_writes_done == n_writes_issued, "R6", "write count",
          n_writes_done, n_writes_issued);
      chk(mem_arr[8'h45] == 32'hAAAA_0005, "R6", "memory content",
          mem_arr[8'h45], 32'hAAAA_0005);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule